// File: doc/BRIEF.md
# Key-Sequence Write Guard for a Memory-Controller Control Register

This block stops stray writes from reaching the control register of a memory controller. After reset the control register is closed: writes to it on the register bus are dropped. Software opens it by writing two fixed 32-bit key words, one after the other, to a separate key register. A write that does not fit that sequence bars the control register until the next reset, answers the offending access with a one-cycle bus error and raises a fault interrupt request.

While open, the control register takes software writes. Its top bit is a relock request: writing it as 1 closes the register again, and the same key sequence can open it once more. The controller's busy flag holds any control-register write on the bus until busy drops. The stored control fields go straight to the controller.

Top module: `reg_unlock_guard`

## Requirements
- R1: After reset the register is closed, `unlocked` is 0, `fault_irq` is 0, `ctrl_fields` is 0, and a control read returns 0x80000000.
- R2: A control-register write (word address 1) made while the register is closed leaves `ctrl_fields` unchanged.
- R3: A key-register write (word address 0) of 0x45670123 followed by a key write of 0xCDEF89AB opens the register. `unlocked` rises on the clock after the second key. After that, control writes load bits 30:0 into `ctrl_fields`.
- R4: A first key word other than 0x45670123 bars the register, with `bus_err` high on that access and `fault_irq` high from the next cycle.
- R5: After a correct first key, a second key word other than 0xCDEF89AB bars the register with the same error and interrupt. Sending 0xCDEF89AB as the first key also counts as a wrong key.
- R6: A key write made while the register is open bars it, raises `bus_err` on that access and raises `fault_irq`.
- R7: Once the register is barred, it stays barred until reset. Key writes, including the correct pair, raise no error and change nothing, and control writes are dropped.
- R8: A control write with bit 31 set, made while open, stores bits 30:0 and closes the register. Bit 31 of a control read is 1 whenever the register is closed or barred, and 0 when it is open.
- R9: A control write made while `busy` is 1 holds `bus_ready` low and does not take effect. It completes in the first cycle that `busy` is 0.
- R10: `bus_err` rises only on a key write that breaks the sequence, and lasts a single cycle.
- R11: Reads of the key register return 0.
- R12: Reads, and dropped control writes, that come between the two keys leave the sequence intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address (key = 0, control = 1 by default) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| bus_ready | output | 1 | Access completes this cycle |
| bus_err | output | 1 | Error response for a bad key write |
| busy | input | 1 | Controller operation in progress |
| unlocked | output | 1 | Control register is open |
| fault_irq | output | 1 | Fault interrupt request, held until reset |
| ctrl_fields | output | 31 | Stored control fields |

## Verification
The bench feeds each wrong-key variant into a fresh reset: a bad first word, a bad second word, the two words swapped, and a key sent while already open. A design that checked only the second key would open the register instead of raising an error. Once barred, the bench replays the correct pair. A design whose lockout does not stick would reopen here, or flag a second error. A control write is held against busy for several cycles, which catches a design that commits the write early or fails to stall. Reads and dropped writes are placed between the two keys to catch a sequencer that resets on any bus activity.

// File: rtl/reg_unlock_pkg.sv
package reg_unlock_pkg;

    localparam int WORD_W   = 32;
    localparam int FIELD_W  = WORD_W - 1;
    localparam int LOCK_POS = WORD_W - 1;

    localparam logic [WORD_W-1:0] KEY_FIRST  = 32'h4567_0123;
    localparam logic [WORD_W-1:0] KEY_SECOND = 32'hCDEF_89AB;

    typedef enum logic [1:0] {
        GS_CLOSED = 2'd0,
        GS_HALF   = 2'd1,
        GS_OPEN   = 2'd2,
        GS_BARRED = 2'd3
    } guard_state_e;

    typedef struct packed {
        logic key_wr;
        logic ctrl_wr;
        logic ctrl_rd;
    } bus_dec_t;

    typedef struct packed {
        guard_state_e nxt;
        logic         bad;
    } key_step_t;

    function automatic logic state_is_open(guard_state_e s);
        return s == GS_OPEN;
    endfunction

    // Outcome of one key-register write in a given state.
    function automatic key_step_t key_step(guard_state_e s, logic [WORD_W-1:0] w);
        key_step_t r;
        r.nxt = s;
        r.bad = 1'b0;
        case (s)
            GS_CLOSED: begin
                if (w == KEY_FIRST) r.nxt = GS_HALF;
                else begin r.nxt = GS_BARRED; r.bad = 1'b1; end
            end
            GS_HALF: begin
                if (w == KEY_SECOND) r.nxt = GS_OPEN;
                else begin r.nxt = GS_BARRED; r.bad = 1'b1; end
            end
            GS_OPEN: begin
                r.nxt = GS_BARRED;
                r.bad = 1'b1;
            end
            default: begin
                r.nxt = GS_BARRED;
                r.bad = 1'b0;
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/reg_unlock_decode.sv
module reg_unlock_decode
    import reg_unlock_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int KEY_OFS  = 0,
    parameter int CTRL_OFS = 1
) (
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic              busy,
    output bus_dec_t          dec,
    output logic              ready,
    output logic              ctrl_go
);

    localparam logic [ADDR_W-1:0] KEY_ADDR  = ADDR_W'(KEY_OFS);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(CTRL_OFS);

    logic hit_key, hit_ctrl;

    always_comb begin
        hit_key     = req && (addr == KEY_ADDR);
        hit_ctrl    = req && (addr == CTRL_ADDR);
        dec.key_wr  = hit_key && we;
        dec.ctrl_wr = hit_ctrl && we;
        dec.ctrl_rd = hit_ctrl && !we;
        // only control writes wait on the controller
        ready       = !(dec.ctrl_wr && busy);
        ctrl_go     = dec.ctrl_wr && !busy;
    end

endmodule

// File: rtl/reg_unlock_keyseq.sv
module reg_unlock_keyseq
    import reg_unlock_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              key_wr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              relock,
    output guard_state_e      state,
    output logic              bad_key
);

    key_step_t    step;
    guard_state_e state_nxt;

    always_comb begin
        step      = key_step(state, wdata);
        state_nxt = state;
        bad_key   = 1'b0;
        if (key_wr) begin
            state_nxt = step.nxt;
            bad_key   = step.bad;
        end else if (relock && state == GS_OPEN) begin
            state_nxt = GS_CLOSED;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= GS_CLOSED;
        else     state <= state_nxt;
    end

endmodule

// File: rtl/reg_unlock_ctrl.sv
module reg_unlock_ctrl
    import reg_unlock_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               go,
    input  logic               open,
    input  logic [WORD_W-1:0]  wdata,
    output logic [FIELD_W-1:0] fields,
    output logic               relock
);

    logic take;

    always_comb begin
        take   = go && open;
        relock = take && wdata[LOCK_POS];
    end

    always_ff @(posedge clk) begin
        if (rst)       fields <= '0;
        else if (take) fields <= wdata[FIELD_W-1:0];
    end

endmodule

// File: rtl/reg_unlock_guard.sv
module reg_unlock_guard
    import reg_unlock_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int KEY_OFS  = 0,
    parameter int CTRL_OFS = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_req,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [WORD_W-1:0]  bus_wdata,
    output logic [WORD_W-1:0]  bus_rdata,
    output logic               bus_ready,
    output logic               bus_err,
    input  logic               busy,
    output logic               unlocked,
    output logic               fault_irq,
    output logic [FIELD_W-1:0] ctrl_fields
);

    bus_dec_t     dec;
    logic         ctrl_go;
    logic         relock;
    guard_state_e gstate;
    logic         is_open;

    reg_unlock_decode #(
        .ADDR_W  (ADDR_W),
        .KEY_OFS (KEY_OFS),
        .CTRL_OFS(CTRL_OFS)
    ) u_decode (
        .req    (bus_req),
        .we     (bus_we),
        .addr   (bus_addr),
        .busy   (busy),
        .dec    (dec),
        .ready  (bus_ready),
        .ctrl_go(ctrl_go)
    );

    reg_unlock_keyseq u_keyseq (
        .clk    (clk),
        .rst    (rst),
        .key_wr (dec.key_wr),
        .wdata  (bus_wdata),
        .relock (relock),
        .state  (gstate),
        .bad_key(bus_err)
    );

    always_comb is_open = state_is_open(gstate);

    reg_unlock_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .go    (ctrl_go),
        .open  (is_open),
        .wdata (bus_wdata),
        .fields(ctrl_fields),
        .relock(relock)
    );

    always_comb begin
        unlocked  = is_open;
        fault_irq = (gstate == GS_BARRED);
        bus_rdata = '0;
        if (dec.ctrl_rd) bus_rdata = {!is_open, ctrl_fields};
    end

endmodule

// File: rtl/reg_unlock_guard_chk.sv
module reg_unlock_guard_chk
    import reg_unlock_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int KEY_OFS  = 0,
    parameter int CTRL_OFS = 1
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_req,
    input logic               bus_we,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [WORD_W-1:0]  bus_rdata,
    input logic               bus_ready,
    input logic               bus_err,
    input logic               busy,
    input logic               unlocked,
    input logic               fault_irq,
    input logic [FIELD_W-1:0] ctrl_fields
);

    localparam logic [ADDR_W-1:0] KA = ADDR_W'(KEY_OFS);
    localparam logic [ADDR_W-1:0] CA = ADDR_W'(CTRL_OFS);

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (!unlocked && !fault_irq && ctrl_fields == '0));

    assert_closed_drop_R2: assert property (@(posedge clk) disable iff (rst)
        (!unlocked && bus_req && bus_we && bus_addr == CA) |=> $stable(ctrl_fields));

    assert_err_raises_irq_R4: assert property (@(posedge clk) disable iff (rst)
        bus_err |=> fault_irq);

    assert_bar_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        fault_irq |=> (fault_irq && !unlocked));

    assert_lock_readback_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_we && bus_addr == CA) |-> (bus_rdata[WORD_W-1] == !unlocked));

    assert_busy_stall_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we && bus_addr == CA && busy) |-> !bus_ready);

    assert_err_source_R10: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> (bus_req && bus_we && bus_addr == KA && !fault_irq));

    assert_err_single_R10: assert property (@(posedge clk) disable iff (rst)
        bus_err |=> !bus_err);

endmodule

bind reg_unlock_guard reg_unlock_guard_chk #(
    .ADDR_W  (ADDR_W),
    .KEY_OFS (KEY_OFS),
    .CTRL_OFS(CTRL_OFS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .bus_ready  (bus_ready),
    .bus_err    (bus_err),
    .busy       (busy),
    .unlocked   (unlocked),
    .fault_irq  (fault_irq),
    .ctrl_fields(ctrl_fields)
);

// File: tb/reg_unlock_guard_test.sv
module reg_unlock_guard_test;
    import reg_unlock_pkg::*;

    localparam int ADDR_W = 4;
    localparam logic [ADDR_W-1:0] KA = 4'd0;
    localparam logic [ADDR_W-1:0] CA = 4'd1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req = 1'b0;
    logic we = 1'b0;
    logic busy = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic ready, err, unl, irq;
    logic [30:0] fields;

    always #4 clk = ~clk;

    reg_unlock_guard uut (
        .clk(clk), .rst(rst), .bus_req(req), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .bus_ready(ready), .bus_err(err),
        .busy(busy), .unlocked(unl), .fault_irq(irq), .ctrl_fields(fields)
    );

    typedef enum {K_READY, K_ERR, K_RDATA, K_UNL, K_IRQ, K_FIELDS} kind_e;
    typedef struct {
        string       tag;
        kind_e       kind;
        logic [31:0] exp;
    } item_t;

    item_t sbq[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    event chk_ev;

    function automatic logic [31:0] observe(kind_e k);
        case (k)
            K_READY:  return {31'd0, ready};
            K_ERR:    return {31'd0, err};
            K_RDATA:  return rdata;
            K_UNL:    return {31'd0, unl};
            K_IRQ:    return {31'd0, irq};
            default:  return {1'b0, fields};
        endcase
    endfunction

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            @(chk_ev);
            while (sbq.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = sbq.pop_front();
                act = observe(it.kind);
                n_cmp++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s %s: actual %h expected %h", it.tag, it.kind.name(), act, it.exp);
                end
            end
        end
    end

    task automatic expect_val(string tag, kind_e k, logic [31:0] e);
        item_t it;
        it.tag = tag; it.kind = k; it.exp = e;
        sbq.push_back(it);
        -> chk_ev;
    endtask

    task automatic do_reset();
        rst = 1'b1; req = 1'b0; we = 1'b0; busy = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
    endtask

    task automatic drive(bit w, logic [ADDR_W-1:0] a, logic [31:0] d);
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d;
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        req = 1'b0; we = 1'b0;
        #1;
    endtask

    task automatic wr_key(string tag, logic [31:0] d, bit exp_err);
        drive(1'b1, KA, d);
        expect_val(tag, K_READY, 32'd1);
        expect_val(tag, K_ERR, {31'd0, exp_err});
        idle();
        expect_val("R10", K_ERR, 32'd0);
    endtask

    task automatic wr_ctrl(string tag, logic [31:0] d);
        drive(1'b1, CA, d);
        expect_val(tag, K_READY, 32'd1);
        expect_val(tag, K_ERR, 32'd0);
        idle();
    endtask

    task automatic rd_ctrl(string tag, logic [31:0] e);
        drive(1'b0, CA, 32'd0);
        expect_val(tag, K_RDATA, e);
        idle();
    endtask

    task automatic state_chk(string tag, bit u, bit q, logic [30:0] f);
        expect_val(tag, K_UNL, {31'd0, u});
        expect_val(tag, K_IRQ, {31'd0, q});
        expect_val(tag, K_FIELDS, {1'b0, f});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset();
        state_chk("R1", 1'b0, 1'b0, 31'd0);
        rd_ctrl("R1", 32'h8000_0000);

        // R2: writes ignored while closed
        wr_ctrl("R2", 32'h0000_00FF);
        state_chk("R2", 1'b0, 1'b0, 31'd0);

        // R11: key register reads zero
        drive(1'b0, KA, 32'd0);
        expect_val("R11", K_RDATA, 32'd0);
        idle();

        // R3 + R12: unlock with activity between keys
        wr_key("R3", KEY_FIRST, 1'b0);
        rd_ctrl("R12", 32'h8000_0000);
        wr_ctrl("R12", 32'h0000_0005);
        state_chk("R12", 1'b0, 1'b0, 31'd0);
        wr_key("R3", KEY_SECOND, 1'b0);
        state_chk("R3", 1'b1, 1'b0, 31'd0);
        wr_ctrl("R3", 32'h1234_5678);
        state_chk("R3", 1'b1, 1'b0, 31'h1234_5678);
        rd_ctrl("R8", 32'h1234_5678);

        // R9: busy stalls a control write
        busy = 1'b1;
        drive(1'b1, CA, 32'h0000_0ABC);
        expect_val("R9", K_READY, 32'd0);
        repeat (3) begin
            @(negedge clk);
            #1;
            expect_val("R9", K_READY, 32'd0);
            expect_val("R9", K_FIELDS, 32'h1234_5678);
        end
        @(negedge clk);
        busy = 1'b0;
        #1;
        expect_val("R9", K_READY, 32'd1);
        idle();
        expect_val("R9", K_FIELDS, 32'h0000_0ABC);

        // R8: software relock, then readback and reopen
        wr_ctrl("R8", 32'h8000_0011);
        state_chk("R8", 1'b0, 1'b0, 31'h11);
        rd_ctrl("R8", 32'h8000_0011);
        wr_ctrl("R8", 32'h0000_0022);
        state_chk("R8", 1'b0, 1'b0, 31'h11);
        wr_key("R8", KEY_FIRST, 1'b0);
        wr_key("R8", KEY_SECOND, 1'b0);
        state_chk("R8", 1'b1, 1'b0, 31'h11);

        // R6: key write while open
        wr_key("R6", KEY_FIRST, 1'b1);
        state_chk("R6", 1'b0, 1'b1, 31'h11);
        rd_ctrl("R8", 32'h8000_0011);

        // R7: barred state ignores everything
        wr_key("R7", KEY_FIRST, 1'b0);
        wr_key("R7", KEY_SECOND, 1'b0);
        state_chk("R7", 1'b0, 1'b1, 31'h11);
        wr_ctrl("R7", 32'h0000_0033);
        state_chk("R7", 1'b0, 1'b1, 31'h11);

        // R4: bad first key
        do_reset();
        state_chk("R1", 1'b0, 1'b0, 31'd0);
        wr_key("R4", 32'hDEAD_BEEF, 1'b1);
        state_chk("R4", 1'b0, 1'b1, 31'd0);

        // R5: bad second key
        do_reset();
        wr_key("R5", KEY_FIRST, 1'b0);
        wr_key("R5", KEY_FIRST, 1'b1);
        state_chk("R5", 1'b0, 1'b1, 31'd0);

        // R5: keys in swapped order
        do_reset();
        wr_key("R5", KEY_SECOND, 1'b1);
        wr_key("R7", KEY_FIRST, 1'b0);
        state_chk("R5", 1'b0, 1'b1, 31'd0);

        @(negedge clk);
        #1;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule